// File: doc/BRIEF.md
# Tiled View Address Generator

This block converts a pixel coordinate inside a two-dimensional tiled container into a 32-bit system address. The address encodes the element format and a view orientation, so one buffer can be fetched upright, rotated or mirrored just by choosing a different orientation code. For each request the block also returns the line stride of the selected view, an out-of-range flag, and the number of bytes one element occupies.

Requests arrive on a valid/ready stream that carries a format code, an orientation code and the x and y coordinates. Results leave on a second valid/ready stream, one registered cycle after acceptance. An input is accepted when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever the output register is empty or the consumer is taking its contents in the same cycle. A result held with `out_ready` low stays unchanged until it is taken. The container is 14 bits wide and 13 bits high in 8-bit coordinates, which gives a 27-bit offset field.

Top module: `tiled_view_addr`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A request accepted on one edge appears on the output at the next edge with `out_valid` high. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.
- R3: For an in-range request, address bits [31:29] carry the orientation code and bits [28:27] carry the format code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode).
- R4: Each format has an x-shift and a y-shift: 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page (6,6). The usable x width is 14 minus the x-shift, the usable y width is 13 minus the y-shift, and each mask is all ones over its width.
- R5: With orientation bit 2 clear, address bits [26:0] hold ((y << x width) + x) shifted left by (x-shift + y-shift).
- R6: Orientation bit 0 XORs x with its mask and orientation bit 1 XORs y with its mask, before the offset is formed.
- R7: With orientation bit 2 set, the offset is ((x << y width) + y) shifted left by (x-shift + y-shift).
- R8: If x exceeds its mask or y exceeds its mask, the whole address is zero and `out_oor` is high. Otherwise `out_oor` is low.
- R9: `out_stride` is 1 << (13 + x-shift) when orientation bit 2 is set, and 1 << (14 + y-shift) otherwise.
- R10: `out_bpe` reports the bytes per element: 1, 2, 4 and 1 for format codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can take a request |
| in_fmt | input | 2 | Element format code |
| in_orient | input | 3 | Orientation: bit0 x-invert, bit1 y-invert, bit2 swap |
| in_x | input | 16 | Column coordinate |
| in_y | input | 16 | Row coordinate |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Packed system address |
| out_stride | output | 32 | Line stride in bytes for the view |
| out_oor | output | 1 | Coordinate outside the usable range |
| out_bpe | output | 3 | Bytes per element |

## Verification
The bench probes coordinates exactly at each format's mask and one step beyond it. A design with an off-by-one mask either zeroes a legal address or packs an illegal one. It runs every format against all eight orientation codes to catch swapped invert bits, a wrong shift in page mode, or the swap branch using the wrong axis width, any of which moves the address. It also stalls the consumer while a second request waits, to expose a result that changes or is lost under back-pressure.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } fmt_e;

  localparam int ORI_XINV = 0;
  localparam int ORI_YINV = 1;
  localparam int ORI_SWAP = 2;
  localparam int SH_W     = 5;

  typedef struct packed {
    logic [SH_W-1:0] xs;
    logic [SH_W-1:0] ys;
    logic [SH_W-1:0] xbits;
    logic [SH_W-1:0] ybits;
    logic [2:0]      bpe;
  } geom_t;
endpackage

// File: rtl/tva_geom.sv
module tva_geom
  import tva_pkg::*;
#(
  parameter int CW_BITS   = 14,
  parameter int CH_BITS   = 13,
  parameter int SLOT_XBIT = 6,
  parameter int SLOT_YBIT = 6
) (
  input  logic [1:0] fmt,
  output geom_t      geom
);
  localparam int NFMT = 4;

  geom_t table_q [NFMT];

  // One geometry entry per format code, chosen at elaboration.
  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    localparam int XS  = (f == 3) ? SLOT_XBIT : (f == 2) ? 1 : 0;
    localparam int YS  = (f == 3) ? SLOT_YBIT : (f == 0) ? 0 : 1;
    localparam int BPE = (f == 1) ? 2 : (f == 2) ? 4 : 1;
    assign table_q[f].xs    = SH_W'(XS);
    assign table_q[f].ys    = SH_W'(YS);
    assign table_q[f].xbits = SH_W'(CW_BITS - XS);
    assign table_q[f].ybits = SH_W'(CH_BITS - YS);
    assign table_q[f].bpe   = 3'(BPE);
  end

  assign geom = table_q[fmt];
endmodule

// File: rtl/tva_map.sv
module tva_map
  import tva_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int COORD_W = 16,
  parameter int OFF_W   = CW_BITS + CH_BITS
) (
  input  geom_t              geom,
  input  logic [2:0]         orient,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic [OFF_W-1:0]   offset,
  output logic [31:0]        stride,
  output logic               oor
);
  logic [31:0] xmask, ymask, xw, yw, xm, ym, lin, shifted;

  always_comb begin
    xmask = (32'd1 << geom.xbits) - 32'd1;
    ymask = (32'd1 << geom.ybits) - 32'd1;
    xw    = 32'(x);
    yw    = 32'(y);
    oor   = (xw > xmask) || (yw > ymask);
    xm    = orient[ORI_XINV] ? (xw ^ xmask) : xw;
    ym    = orient[ORI_YINV] ? (yw ^ ymask) : yw;
    if (orient[ORI_SWAP]) begin
      lin    = (xm << geom.ybits) + ym;
      stride = 32'd1 << (SH_W'(CH_BITS) + geom.xs);
    end else begin
      lin    = (ym << geom.xbits) + xm;
      stride = 32'd1 << (SH_W'(CW_BITS) + geom.ys);
    end
    shifted = lin << (geom.xs + geom.ys);
    offset  = oor ? '0 : shifted[OFF_W-1:0];
  end
endmodule

// File: rtl/tva_stage.sv
module tva_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  assert_hold_under_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_accept_to_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_empty_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
  import tva_pkg::*;
#(
  parameter int CW_BITS   = 14,
  parameter int CH_BITS   = 13,
  parameter int SLOT_XBIT = 6,
  parameter int SLOT_YBIT = 6,
  parameter int COORD_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_orient,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_addr,
  output logic [31:0]        out_stride,
  output logic               out_oor,
  output logic [2:0]         out_bpe
);
  localparam int OFF_W  = CW_BITS + CH_BITS;
  localparam int ADDR_W = OFF_W + 5;
  localparam int PAY_W  = 3 + 1 + 32 + ADDR_W;

  geom_t              geom;
  logic [OFF_W-1:0]   offset;
  logic [31:0]        stride;
  logic               oor;
  logic [ADDR_W-1:0]  addr_c;
  logic [PAY_W-1:0]   pay_in, pay_out;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_XBIT(SLOT_XBIT), .SLOT_YBIT(SLOT_YBIT)
  ) u_geom (
    .fmt  (in_fmt),
    .geom (geom)
  );

  tva_map #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .COORD_W(COORD_W), .OFF_W(OFF_W)
  ) u_map (
    .geom   (geom),
    .orient (in_orient),
    .x      (in_x),
    .y      (in_y),
    .offset (offset),
    .stride (stride),
    .oor    (oor)
  );

  assign addr_c = oor ? '0 : {in_orient, in_fmt, offset};
  assign pay_in = {geom.bpe, oor, stride, addr_c};

  tva_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_addr   = 32'(pay_out[ADDR_W-1:0]);
  assign out_stride = pay_out[ADDR_W +: 32];
  assign out_oor    = pay_out[ADDR_W+32];
  assign out_bpe    = pay_out[ADDR_W+33 +: 3];

  assert_oor_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_oor |-> out_addr == 32'd0);

  assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_stride) == 1);

  assert_bpe_pow2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_bpe) == 1);

  assert_fields_follow_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !oor |=> out_addr[31:27] == {$past(in_orient), $past(in_fmt)});
endmodule

// File: tb/tb_tiled_view_addr.sv
module tb_tiled_view_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_fmt = '0;
  logic [2:0]  in_orient = '0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr, out_stride;
  logic        out_oor;
  logic [2:0]  out_bpe;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tiled_view_addr dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_stride(out_stride), .out_oor(out_oor), .out_bpe(out_bpe)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic int xs_of(int f); return (f == 3) ? 6 : (f == 2) ? 1 : 0; endfunction
  function automatic int ys_of(int f); return (f == 3) ? 6 : (f == 0) ? 0 : 1; endfunction
  function automatic int bpe_of(int f); return (f == 1) ? 2 : (f == 2) ? 4 : 1; endfunction

  function automatic logic [31:0] m_addr(int f, int o, int x, int y);
    int xb = 14 - xs_of(f);
    int yb = 13 - ys_of(f);
    int xm = (1 << xb) - 1;
    int ym = (1 << yb) - 1;
    int lin;
    if (x > xm || y > ym) return 32'd0;
    if ((o & 1) != 0) x = x ^ xm;
    if ((o & 2) != 0) y = y ^ ym;
    lin = ((o & 4) != 0) ? ((x << yb) + y) : ((y << xb) + x);
    return (32'(o) << 29) | (32'(f) << 27) | 32'(lin << (xs_of(f) + ys_of(f)));
  endfunction

  function automatic logic [31:0] m_stride(int f, int o);
    return ((o & 4) != 0) ? (32'd1 << (13 + xs_of(f))) : (32'd1 << (14 + ys_of(f)));
  endfunction

  function automatic logic m_oor(int f, int x, int y);
    return (x > (1 << (14 - xs_of(f))) - 1) || (y > (1 << (13 - ys_of(f))) - 1);
  endfunction

  // Drive one request with the consumer ready; leaves outputs valid at a negedge.
  task automatic send(int f, int o, int x, int y);
    @(negedge clk);
    in_fmt = 2'(f); in_orient = 3'(o); in_x = 16'(x); in_y = 16'(y);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic test_known_points();
    send(0, 0, 5, 3);  chk("R5 8-bit upright", out_addr, 32'h0000C005);
    chk("R2 valid one cycle later", 32'(out_valid), 32'd1);
    send(1, 0, 5, 3);  chk("R4 16-bit shift", out_addr, 32'h0801800A);
    send(3, 0, 1, 1);  chk("R3 page field and shift", out_addr, 32'h18101000);
    send(0, 1, 0, 0);  chk("R6 x-invert", out_addr, 32'h20003FFF);
    send(0, 2, 0, 0);  chk("R6 y-invert", out_addr, 32'h47FFC000);
    send(0, 4, 1, 2);  chk("R7 swap", out_addr, 32'h80002002);
  endtask

  task automatic test_range();
    send(0, 0, 16'h3FFF, 16'h1FFF);
    chk("R8 max in range addr", out_addr, 32'h07FFFFFF);
    chk("R8 max in range flag", 32'(out_oor), 32'd0);
    send(2, 3, 16'h2000, 0);
    chk("R8 x beyond mask addr", out_addr, 32'd0);
    chk("R8 x beyond mask flag", 32'(out_oor), 32'd1);
    send(0, 0, 0, 16'h2000);
    chk("R8 y beyond mask flag", 32'(out_oor), 32'd1);
    send(3, 7, 16'hFF, 16'h80);
    chk("R8 page y beyond mask", out_addr, 32'd0);
  endtask

  task automatic test_stride_bpe();
    send(0, 0, 0, 0); chk("R9 stride 8-bit upright", out_stride, 32'h4000);
    chk("R10 bpe 8-bit", 32'(out_bpe), 32'd1);
    send(3, 4, 0, 0); chk("R9 stride page swapped", out_stride, 32'h80000);
    chk("R10 bpe page", 32'(out_bpe), 32'd1);
    send(2, 0, 0, 0); chk("R10 bpe 32-bit", 32'(out_bpe), 32'd4);
    send(1, 6, 0, 0); chk("R10 bpe 16-bit", 32'(out_bpe), 32'd2);
    chk("R9 stride 16-bit swapped", out_stride, 32'h2000);
  endtask

  task automatic test_sweep();
    int pts [4][2] = '{'{0, 0}, '{7, 11}, '{1000, 500}, '{-1, -1}};
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o++) begin
        for (int p = 0; p < 4; p++) begin
          int x = (pts[p][0] < 0) ? (1 << (14 - xs_of(f))) - 1 : pts[p][0];
          int y = (pts[p][1] < 0) ? (1 << (13 - ys_of(f))) - 1 : pts[p][1];
          send(f, o, x, y);
          chk("R3 R5 R6 R7 sweep addr", out_addr, m_addr(f, o, x, y));
          chk("R9 sweep stride", out_stride, m_stride(f, o));
          chk("R8 sweep flag", 32'(out_oor), 32'(m_oor(f, x, y)));
          chk("R10 sweep bpe", 32'(out_bpe), 32'(bpe_of(f)));
        end
      end
    end
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    in_fmt = 2'd1; in_orient = 3'd5; in_x = 16'd9; in_y = 16'd4;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R2 first result held", out_addr, m_addr(1, 5, 9, 4));
    in_fmt = 2'd2; in_orient = 3'd2; in_x = 16'd3; in_y = 16'd6;
    chk("R2 in_ready low while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 stable under stall", out_addr, m_addr(1, 5, 9, 4));
    chk("R2 valid under stall", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second result after release", out_addr, m_addr(2, 2, 3, 6));
    @(negedge clk);
    chk("R2 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_known_points();
    test_range();
    test_stride_bpe();
    test_backpressure();
    test_sweep();
    finish_run();
  end
endmodule